// File: doc/BRIEF.md
# Page Translation Cache with Global-Preserving Flush

This block keeps a small, fully associative set of finished page translations in front of a page-table walker. Each entry is keyed by a logical page number and by an address-space bit (user or supervisor). It holds a physical page number and a set of attributes: global, supervisor-only, a 2-bit cache mode, modified, write-protect and two user page attribute bits. A lookup is answered in the same cycle, and the answer is one of three results. A hit returns the physical address and its attributes. A miss sends the access to the walker. A fault reports a protection violation and does not start a walk.

The walker writes finished translations through a one-cycle fill port. Software-style maintenance arrives on a flush port with four variants. Two of these variants spare entries marked global, so that translations shared by every address space survive a context switch. The page size can be 4 KB or 8 KB. Changing the page size, or switching translation on or off, empties the cache.

Top module: `xlat_cache`

## Requirements
- R1: A lookup hits when a valid entry has the same space bit and the same page number. The page number is address bits 31..12 with 4 KB pages and bits 31..13 with 8 KB pages. On a hit, lk_paddr is the stored page above the offset. With 8 KB pages, bits 12..0 come from the logical address.
- R2: With translation on and no matching entry, a lookup reports lk_miss. At most one entry ever matches a lookup. With lk_valid low, every lookup output is zero.
- R3: A user-space lookup (lk_super=0) that matches an entry with the supervisor-only bit set reports lk_fault and not lk_miss. At most one of lk_hit, lk_miss and lk_fault is high.
- R4: A write lookup that matches an entry with write-protect set reports lk_fault.
- R5: A write lookup that matches an entry with the modified bit clear, and that does not fault, reports lk_miss. A read of the same entry hits.
- R6: On a hit, lk_cmode carries the entry's 2-bit cache mode (00 write-through, 01 copy-back, 10 uncached serialized, 11 uncached) and lk_upa carries the entry's two user page attribute bits. Both outputs are zero when there is no hit.
- R7: A fill first overwrites an entry that has the same page and space. Otherwise it takes the lowest-numbered invalid entry. Otherwise it takes the entry at the round-robin pointer, which then advances and wraps after the last entry.
- R8: flush_op 00 invalidates every entry.
- R9: flush_op 01 invalidates every entry whose global bit is clear. Global entries stay valid.
- R10: flush_op 10 invalidates the entries that match flush_vpn and flush_super, global or not.
- R11: flush_op 11 invalidates the entries that match flush_vpn and flush_super only if their global bit is clear.
- R12: When flush_valid and fill_valid are high in the same cycle, the flush takes effect and the fill is discarded.
- R13: A change of big_page or xlat_en since the previous cycle invalidates all entries, discards a fill in that cycle and makes that cycle's lookup miss. While xlat_en is low, fills are ignored and a valid lookup returns lk_paddr = lk_addr with lk_hit, lk_miss and lk_fault low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enabled |
| big_page | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Logical address to translate |
| lk_super | input | 1 | Lookup space: 1 supervisor, 0 user |
| lk_write | input | 1 | Lookup is a write |
| lk_hit | output | 1 | Translation available |
| lk_miss | output | 1 | Walker must be invoked |
| lk_fault | output | 1 | Protection violation |
| lk_paddr | output | ADDR_W | Physical address on hit, or bypass address |
| lk_cmode | output | 2 | Cache mode of the hit entry |
| lk_upa | output | 2 | User page attribute bits of the hit entry |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | ADDR_W-12 | Logical page number being filled |
| fill_super | input | 1 | Space of the filled entry |
| fill_ppn | input | ADDR_W-12 | Physical page number (bit 0 unused with 8 KB pages) |
| fill_glb | input | 1 | Global attribute |
| fill_sprot | input | 1 | Supervisor-only attribute |
| fill_cmode | input | 2 | Cache mode attribute |
| fill_mod | input | 1 | Modified attribute |
| fill_wprot | input | 1 | Write-protect attribute |
| fill_upa | input | 2 | User page attribute bits |
| flush_valid | input | 1 | Flush request |
| flush_op | input | 2 | Flush variant (00 all, 01 non-global, 10 page, 11 page non-global) |
| flush_vpn | input | ADDR_W-12 | Page for the page-directed variants |
| flush_super | input | 1 | Space for the page-directed variants |

## Verification
The tricky coincidence is a fill that lands in the same cycle as a flush, or in the same cycle as a page-size or enable change. Either way the fill must vanish and the invalidation must win. Directed steps drive a page flush together with a fill of a different page, then look up both pages and expect two misses. Randomized traffic also raises fill and flush together, over a narrow range of page numbers. A behavioural model in the bench applies the stated precedence and judges every lookup output on every cycle.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int PAGE_LSB = 12;

  typedef struct packed {
    logic       glb;
    logic       sprot;
    logic [1:0] cmode;
    logic       mod;
    logic       wprot;
    logic [1:0] upa;
  } xlc_attr_t;

  typedef enum logic [1:0] {
    FL_ALL     = 2'b00,
    FL_NONGLB  = 2'b01,
    FL_PAGE    = 2'b10,
    FL_PAGE_NG = 2'b11
  } xlc_flush_e;
endpackage

// File: rtl/xlc_match.sv
module xlc_match #(
  parameter int VPN_W = 20
) (
  input  logic             ent_valid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic             ent_super,
  input  logic [VPN_W-1:0] key_vpn,
  input  logic             key_super,
  input  logic             big_page,
  output logic             hit
);
  logic upper_eq;
  logic low_eq;

  // bit 0 of the page number is ignored with 8 KB pages
  assign upper_eq = (ent_vpn[VPN_W-1:1] == key_vpn[VPN_W-1:1]);
  assign low_eq   = big_page | (ent_vpn[0] == key_vpn[0]);
  assign hit      = ent_valid & (ent_super == key_super) & upper_eq & low_eq;
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   sel,
  output logic               use_rr
);
  // later assignments win: matching entry, then lowest invalid, then pointer
  always_comb begin
    sel    = rr_ptr;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        sel    = IDX_W'(i);
        use_rr = 1'b0;
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel    = IDX_W'(i);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en,
  input  logic              big_page,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_super,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [ADDR_W-1:0] lk_paddr,
  output logic [1:0]        lk_cmode,
  output logic [1:0]        lk_upa,
  input  logic              fill_valid,
  input  logic [ADDR_W-PAGE_LSB-1:0] fill_vpn,
  input  logic              fill_super,
  input  logic [ADDR_W-PAGE_LSB-1:0] fill_ppn,
  input  logic              fill_glb,
  input  logic              fill_sprot,
  input  logic [1:0]        fill_cmode,
  input  logic              fill_mod,
  input  logic              fill_wprot,
  input  logic [1:0]        fill_upa,
  input  logic              flush_valid,
  input  logic [1:0]        flush_op,
  input  logic [ADDR_W-PAGE_LSB-1:0] flush_vpn,
  input  logic              flush_super
);
  localparam int VPN_W = ADDR_W - PAGE_LSB;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d, kill, we;
  logic [ENTRIES-1:0] lk_mv, lk_hv, fl_mv, fi_mv;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic               sup_q  [ENTRIES];
  logic [VPN_W-1:0]   ppn_q  [ENTRIES];
  xlc_attr_t          attr_q [ENTRIES];
  logic               en_q, big_q, cfg_chg, fill_do, use_rr, any_hit;
  logic [IDX_W-1:0]   rr_q, rr_d, vsel;
  xlc_attr_t          fill_attr, hit_attr;
  logic [VPN_W-1:0]   hit_ppn;
  xlc_flush_e         fop;

  assign fop       = xlc_flush_e'(flush_op);
  assign cfg_chg   = (xlat_en != en_q) | (big_page != big_q);
  assign fill_do   = fill_valid & xlat_en & ~flush_valid & ~cfg_chg;
  assign fill_attr = '{glb: fill_glb, sprot: fill_sprot, cmode: fill_cmode,
                       mod: fill_mod, wprot: fill_wprot, upa: fill_upa};

  // three comparators per entry: lookup, flush and fill keys
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlc_match #(.VPN_W(VPN_W)) u_lk (
      .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_super(sup_q[g]),
      .key_vpn(lk_addr[ADDR_W-1:PAGE_LSB]), .key_super(lk_super),
      .big_page(big_page), .hit(lk_mv[g]));
    xlc_match #(.VPN_W(VPN_W)) u_fl (
      .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_super(sup_q[g]),
      .key_vpn(flush_vpn), .key_super(flush_super),
      .big_page(big_page), .hit(fl_mv[g]));
    xlc_match #(.VPN_W(VPN_W)) u_fi (
      .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_super(sup_q[g]),
      .key_vpn(fill_vpn), .key_super(fill_super),
      .big_page(big_page), .hit(fi_mv[g]));
  end

  xlc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_vec(valid_q), .match_vec(fi_mv), .rr_ptr(rr_q),
    .sel(vsel), .use_rr(use_rr));

  // flush decode per entry
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic sel_i;
      unique case (fop)
        FL_ALL:     sel_i = 1'b1;
        FL_NONGLB:  sel_i = ~attr_q[i].glb;
        FL_PAGE:    sel_i = fl_mv[i];
        FL_PAGE_NG: sel_i = fl_mv[i] & ~attr_q[i].glb;
      endcase
      kill[i] = cfg_chg | (flush_valid & sel_i);
    end
  end

  // next state
  always_comb begin
    valid_d = valid_q & ~kill;
    we      = '0;
    rr_d    = rr_q;
    if (fill_do) begin
      we[vsel]      = 1'b1;
      valid_d[vsel] = 1'b1;
      if (use_rr) begin
        rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
      en_q    <= 1'b0;
      big_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
      en_q    <= xlat_en;
      big_q   <= big_page;
    end
  end

  // payload storage, written only under its own enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (we[i]) begin
        vpn_q[i]  <= fill_vpn;
        sup_q[i]  <= fill_super;
        ppn_q[i]  <= fill_ppn;
        attr_q[i] <= fill_attr;
      end
    end
  end

  // lookup read mux
  always_comb begin
    lk_hv    = lk_mv & {ENTRIES{~cfg_chg}};
    hit_ppn  = '0;
    hit_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hv[i]) begin
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_attr = xlc_attr_t'(hit_attr | attr_q[i]);
      end
    end
    any_hit = |lk_hv;
  end

  // lookup result
  always_comb begin
    lk_hit   = 1'b0;
    lk_miss  = 1'b0;
    lk_fault = 1'b0;
    lk_paddr = '0;
    lk_cmode = 2'b00;
    lk_upa   = 2'b00;
    if (lk_valid) begin
      if (!xlat_en) begin
        lk_paddr = lk_addr;
      end else if (!any_hit) begin
        lk_miss = 1'b1;
      end else if ((!lk_super && hit_attr.sprot) || (lk_write && hit_attr.wprot)) begin
        lk_fault = 1'b1;
      end else if (lk_write && !hit_attr.mod) begin
        lk_miss = 1'b1;
      end else begin
        lk_hit   = 1'b1;
        lk_cmode = hit_attr.cmode;
        lk_upa   = hit_attr.upa;
        lk_paddr = big_page ? {hit_ppn[VPN_W-1:1], lk_addr[PAGE_LSB:0]}
                            : {hit_ppn, lk_addr[PAGE_LSB-1:0]};
      end
    end
  end

  // assertions
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_mv)); // R2

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_fault}) <= 1); // R3

  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_op == 2'b00) |=> (valid_q == '0)); // R8

  AST_CFG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (valid_q == '0)); // R13

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |=> (($past(we) & ~valid_q) == '0)); // R7

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_do && use_rr) |=> (rr_q != $past(rr_q))); // R7

  AST_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && flush_valid && flush_op == 2'b00) |=> (valid_q == '0)); // R12

  for (genvar g = 0; g < ENTRIES; g++) begin : g_glb_chk
    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && flush_op[0] && !cfg_chg && valid_q[g] && attr_q[g].glb)
        |=> valid_q[g]); // R9
  end
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int VW = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic xlat_en, big_page;
  logic lk_valid, lk_super, lk_write;
  logic [AW-1:0] lk_addr;
  logic lk_hit, lk_miss, lk_fault;
  logic [AW-1:0] lk_paddr;
  logic [1:0] lk_cmode, lk_upa;
  logic fill_valid, fill_super, fill_glb, fill_sprot, fill_mod, fill_wprot;
  logic [VW-1:0] fill_vpn, fill_ppn;
  logic [1:0] fill_cmode, fill_upa;
  logic flush_valid, flush_super;
  logic [1:0] flush_op;
  logic [VW-1:0] flush_vpn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xlat_cache #(.ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .big_page(big_page),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_super(lk_super), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .lk_cmode(lk_cmode), .lk_upa(lk_upa),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_super(fill_super),
    .fill_ppn(fill_ppn), .fill_glb(fill_glb), .fill_sprot(fill_sprot),
    .fill_cmode(fill_cmode), .fill_mod(fill_mod), .fill_wprot(fill_wprot),
    .fill_upa(fill_upa),
    .flush_valid(flush_valid), .flush_op(flush_op), .flush_vpn(flush_vpn),
    .flush_super(flush_super));

  // ---------------- reference model ----------------
  bit            m_v   [N];
  logic [VW-1:0] m_tag [N];
  logic [VW-1:0] m_ppn [N];
  bit            m_sp  [N];
  logic [7:0]    m_at  [N];   // {glb, sprot, cmode[1:0], mod, wprot, upa[1:0]}
  int            m_rr;
  bit            m_en, m_pg;

  function automatic bit tag_eq(logic [VW-1:0] a, logic [VW-1:0] b, bit pg);
    return pg ? (a[VW-1:1] == b[VW-1:1]) : (a == b);
  endfunction

  function automatic bit flush_hits(int i);
    bit pm;
    bit gl;
    pm = tag_eq(m_tag[i], flush_vpn, m_pg) && (m_sp[i] == flush_super);
    gl = m_at[i][7];
    case (flush_op)
      2'd0: return 1'b1;
      2'd1: return !gl;
      2'd2: return pm;
      default: return pm && !gl;
    endcase
  endfunction

  task automatic model_place();
    int slot = -1;
    for (int i = 0; i < N; i++)
      if (slot < 0 && m_v[i] && tag_eq(m_tag[i], fill_vpn, m_pg) && m_sp[i] == fill_super) slot = i;
    for (int i = 0; i < N; i++)
      if (slot < 0 && !m_v[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[slot]   = 1'b1;
    m_tag[slot] = fill_vpn;
    m_sp[slot]  = fill_super;
    m_ppn[slot] = fill_ppn;
    m_at[slot]  = {fill_glb, fill_sprot, fill_cmode, fill_mod, fill_wprot, fill_upa};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_rr = 0;
      m_en = 1'b0;
      m_pg = 1'b0;
    end else begin
      if (xlat_en != m_en || big_page != m_pg) begin
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      end else if (flush_valid) begin
        for (int i = 0; i < N; i++) if (m_v[i] && flush_hits(i)) m_v[i] = 1'b0;
      end else if (fill_valid && xlat_en) begin
        model_place();
      end
      m_en = xlat_en;
      m_pg = big_page;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_check();
    logic eh = 1'b0, em = 1'b0, ef = 1'b0;
    logic [31:0] ep = '0;
    logic [1:0] ec = '0, eu = '0;
    int idx = -1;
    logic [7:0] at;
    if (lk_valid) begin
      if (!xlat_en) ep = lk_addr;
      else if (xlat_en != m_en || big_page != m_pg) em = 1'b1;
      else begin
        for (int i = 0; i < N; i++)
          if (idx < 0 && m_v[i] && tag_eq(m_tag[i], lk_addr[31:12], m_pg) && m_sp[i] == lk_super) idx = i;
        if (idx < 0) em = 1'b1;
        else begin
          at = m_at[idx];
          if ((!lk_super && at[6]) || (lk_write && at[2])) ef = 1'b1;
          else if (lk_write && !at[3]) em = 1'b1;
          else begin
            eh = 1'b1;
            ec = at[5:4];
            eu = at[1:0];
            ep = m_pg ? {m_ppn[idx][VW-1:1], lk_addr[12:0]} : {m_ppn[idx], lk_addr[11:0]};
          end
        end
      end
    end
    chk("R1", "hit", lk_hit, eh);
    chk("R2", "miss", lk_miss, em);
    chk("R3", "fault", lk_fault, ef);
    chk("R1", "paddr", lk_paddr, ep);
    chk("R6", "cmode", lk_cmode, ec);
    chk("R6", "upa", lk_upa, eu);
  endtask

  always @(negedge clk) if (rst_n === 1'b1 && !done) model_check();

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk);
    #1;
    lk_valid = 1'b0; fill_valid = 1'b0; flush_valid = 1'b0;
  endtask

  task automatic set_fill(logic [VW-1:0] vpn, bit sup, logic [VW-1:0] ppn,
                          bit g, bit s, logic [1:0] cm, bit m, bit w, logic [1:0] upa);
    fill_valid = 1'b1; fill_vpn = vpn; fill_super = sup; fill_ppn = ppn;
    fill_glb = g; fill_sprot = s; fill_cmode = cm; fill_mod = m; fill_wprot = w; fill_upa = upa;
  endtask

  task automatic do_fill(logic [VW-1:0] vpn, bit sup, logic [VW-1:0] ppn,
                         bit g, bit s, logic [1:0] cm, bit m, bit w, logic [1:0] upa);
    set_fill(vpn, sup, ppn, g, s, cm, m, w, upa);
    cyc();
  endtask

  task automatic do_flush(logic [1:0] op, logic [VW-1:0] vpn, bit sup);
    flush_valid = 1'b1; flush_op = op; flush_vpn = vpn; flush_super = sup;
    cyc();
  endtask

  task automatic look(logic [VW-1:0] vpn, logic [11:0] off, bit sup, bit wr,
                      bit eh, bit em, bit ef, string req);
    lk_valid = 1'b1; lk_addr = {vpn, off}; lk_super = sup; lk_write = wr;
    @(negedge clk);
    chk(req, "hit", lk_hit, eh);
    chk(req, "miss", lk_miss, em);
    chk(req, "fault", lk_fault, ef);
    cyc();
  endtask

  task automatic look_pa(logic [VW-1:0] vpn, logic [11:0] off, bit sup,
                         logic [31:0] epa, string req);
    lk_valid = 1'b1; lk_addr = {vpn, off}; lk_super = sup; lk_write = 1'b0;
    @(negedge clk);
    chk(req, "hit", lk_hit, 1'b1);
    chk(req, "paddr", lk_paddr, epa);
    cyc();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; xlat_en = 1'b0; big_page = 1'b0;
    lk_valid = 1'b0; lk_addr = '0; lk_super = 1'b0; lk_write = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_super = 1'b0; fill_ppn = '0;
    fill_glb = 1'b0; fill_sprot = 1'b0; fill_cmode = '0; fill_mod = 1'b0;
    fill_wprot = 1'b0; fill_upa = '0;
    flush_valid = 1'b0; flush_op = '0; flush_vpn = '0; flush_super = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();

    // reset state: outputs idle (R2)
    @(negedge clk);
    chk("R2", "idle hit", lk_hit, 1'b0);
    chk("R2", "idle paddr", lk_paddr, 32'h0);
    cyc();

    // R13: bypass while disabled, fill ignored
    look(20'h12345, 12'h678, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R13");
    do_fill(20'h00010, 1'b0, 20'hAAAAA, 0, 0, 2'b00, 1, 0, 2'b00);
    // R13: enable together with a fill: the fill is dropped
    xlat_en = 1'b1;
    set_fill(20'h00011, 1'b0, 20'hBBBBB, 0, 0, 2'b00, 1, 0, 2'b00);
    cyc();
    look(20'h00010, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R13");
    look(20'h00011, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R13");

    // R1 hit and physical address, R2 space mismatch misses
    do_fill(20'h00010, 1'b0, 20'hABCDE, 0, 0, 2'b01, 1, 0, 2'b10);
    look_pa(20'h00010, 12'h5A5, 1'b0, 32'hABCDE5A5, "R1");
    look(20'h00010, 12'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");

    // R3 supervisor-only entry seen from user space
    do_fill(20'h00020, 1'b0, 20'h11111, 0, 1, 2'b00, 1, 0, 2'b00);
    look(20'h00020, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");

    // R4 write-protect
    do_fill(20'h00030, 1'b0, 20'h22222, 0, 0, 2'b00, 1, 1, 2'b00);
    look(20'h00030, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    look(20'h00030, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");

    // R5 write to clean entry misses; refill replaces same entry (R7)
    do_fill(20'h00040, 1'b0, 20'h33333, 0, 0, 2'b00, 0, 0, 2'b00);
    look(20'h00040, 12'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    look(20'h00040, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    do_fill(20'h00040, 1'b0, 20'h33333, 0, 0, 2'b00, 1, 0, 2'b00);
    look(20'h00040, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");

    // R7 fill up, then round-robin eviction of slots 0 and 1
    for (int k = 5; k <= 8; k++) do_fill(20'(k * 16), 1'b0, 20'(k), 0, 0, 2'b00, 1, 0, 2'b00);
    do_fill(20'h00090, 1'b0, 20'h99999, 0, 0, 2'b00, 1, 0, 2'b00);
    look(20'h00010, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    look(20'h00090, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    do_fill(20'h000A0, 1'b0, 20'hAAAAA, 0, 0, 2'b00, 1, 0, 2'b00);
    look(20'h00020, 12'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    look(20'h00020, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");

    // R6 every cache-mode code and attribute pins (judged by the model)
    for (int c = 0; c < 4; c++) begin
      do_fill(20'(256 + c), 1'b1, 20'(c), 0, 0, 2'(c), 1, 0, 2'(3 - c));
      look(20'(256 + c), 12'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    end

    // R11 / R10 page flushes against a global entry
    do_fill(20'h00200, 1'b0, 20'h20000, 1, 0, 2'b00, 1, 0, 2'b00);
    do_flush(2'b11, 20'h00200, 1'b0);
    look(20'h00200, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
    do_flush(2'b11, 20'h00090, 1'b0);
    look(20'h00090, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
    do_flush(2'b10, 20'h00200, 1'b0);
    look(20'h00200, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10");

    // R9 non-global flush of everything
    do_fill(20'h00300, 1'b0, 20'h30000, 1, 0, 2'b00, 1, 0, 2'b00);
    do_fill(20'h00301, 1'b0, 20'h30001, 0, 0, 2'b00, 1, 0, 2'b00);
    do_flush(2'b01, 20'h0, 1'b0);
    look(20'h00300, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    look(20'h00301, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    look(20'h00030, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");

    // R12 flush and fill in the same cycle
    set_fill(20'h00400, 1'b0, 20'h40000, 0, 0, 2'b00, 1, 0, 2'b00);
    do_flush(2'b10, 20'h00300, 1'b0);
    look(20'h00400, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R12");
    look(20'h00300, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R12");

    // R8 flush all
    do_fill(20'h00500, 1'b0, 20'h50000, 1, 0, 2'b00, 1, 0, 2'b00);
    do_flush(2'b00, 20'h0, 1'b0);
    look(20'h00500, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");

    // R13 page-size change empties; R1 8 KB matching and address
    do_fill(20'h00600, 1'b0, 20'h60000, 0, 0, 2'b00, 1, 0, 2'b00);
    big_page = 1'b1;
    cyc();
    look(20'h00600, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R13");
    do_fill(20'h00602, 1'b0, 20'h12345, 0, 0, 2'b00, 1, 0, 2'b00);
    look_pa(20'h00603, 12'hABC, 1'b0, {19'h12345 >> 1, 1'b1, 12'hABC}, "R1");
    big_page = 1'b0;
    cyc();
    look(20'h00602, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R13");

    // randomized traffic over a narrow page range, judged by the model
    for (int k = 0; k < 3000; k++) begin
      lk_valid    = 1'($urandom);
      lk_addr     = {16'h0, 4'($urandom), 12'($urandom)};
      lk_super    = 1'($urandom);
      lk_write    = 1'($urandom);
      fill_valid  = ($urandom % 3) == 0;
      fill_vpn    = {16'h0, 4'($urandom)};
      fill_super  = 1'($urandom);
      fill_ppn    = 20'($urandom);
      fill_glb    = 1'($urandom);
      fill_sprot  = ($urandom % 4) == 0;
      fill_cmode  = 2'($urandom);
      fill_mod    = ($urandom % 4) != 0;
      fill_wprot  = ($urandom % 4) == 0;
      fill_upa    = 2'($urandom);
      flush_valid = ($urandom % 12) == 0;
      flush_op    = 2'($urandom);
      flush_vpn   = {16'h0, 4'($urandom)};
      flush_super = 1'($urandom);
      if ($urandom % 250 == 0) big_page = ~big_page;
      xlat_en     = ($urandom % 200) != 0;
      @(posedge clk);
      #1;
    end
    xlat_en = 1'b1;
    cyc();
    cyc();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule